// File: doc/BRIEF.md
# Power-On Fail-Safe Fan Sequencer

After a reset, this block decides how the cooling fans behave until system software has talked to the device. It first looks at a flag that says whether the processor supply rail is above its threshold. When the rail is up, a fail-safe countdown starts. Software that reaches the device with a valid bus transaction before the countdown ends sends the block straight to normal operation with default register settings. If the countdown runs out first, the fans are forced to full speed. They stay there until a valid access arrives. That access turns them off, loads the defaults and starts normal operation.

When the rail is down at the check, no countdown runs. The block waits for an access and moves to normal operation when one arrives. It keeps watching the rail while it waits, and starts the countdown as soon as the rail comes up. Bus decoding and PWM generation sit outside the block. The block receives a one-cycle pulse for each valid transaction and a periodic tick that paces the countdown. The countdown length is a parameter: the default is 4.6 s divided by the tick period.

States and transitions:
- `ST_CHECK`: the state after reset.
  - An access goes to `ST_RUN`.
  - Otherwise a high rail goes to `ST_COUNT`.
  - Otherwise the block goes to `ST_WAIT`.
- `ST_WAIT`: the rail was low.
  - An access goes to `ST_RUN`.
  - Otherwise a high rail goes to `ST_COUNT`.
- `ST_COUNT`: the countdown runs.
  - An access goes to `ST_RUN`.
  - Otherwise the final tick goes to `ST_FULL`.
- `ST_FULL`: the fans run at full speed.
  - An access goes to `ST_RUN`, with a fans-off pulse.
- `ST_RUN`: normal operation, left only by reset.

Top module: `fanguard_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after reset is released, `fan_full`, `fans_off`, `load_dflt` and `run_normal` are all 0.
- R2: With `rail_ok`=1 at the check, an access during the countdown gives a one-cycle `load_dflt` pulse and sets `run_normal`. `fan_full` stays 0.
- R3: `fan_full` rises after the TICKS-th tick counted in `ST_COUNT`, and not earlier. TICKS = TIMEOUT_US / TICK_US, which is 10 in the bench. It stays high until an access or a reset.
- R4: An access in `ST_FULL` clears `fan_full`, pulses `fans_off` and `load_dflt` together for one cycle, and sets `run_normal`.
- R5: With `rail_ok`=0 at the check, ticks have no effect. `fan_full` stays 0, and an access gives a `load_dflt` pulse and `run_normal`.
- R6: In `ST_WAIT`, `rail_ok` going high starts the countdown. It then expires after TICKS further ticks.
- R7: An access that arrives in the same cycle as the expiring tick wins. The outcome is `load_dflt` and `run_normal`, with no `fan_full` and no `fans_off`.
- R8: `run_normal` stays 1 until reset. In `ST_RUN`, further accesses and ticks produce no pulses.
- R9: A synchronous reset from any state returns the block to `ST_CHECK` and clears every output.
- R10: Every new entry to `ST_COUNT` restarts the countdown from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rail_ok | input | 1 | Processor rail above threshold |
| bus_hit | input | 1 | One-cycle pulse per valid addressed transaction |
| tick | input | 1 | Countdown time base pulse |
| fan_full | output | 1 | Force fans to full speed |
| fans_off | output | 1 | One-cycle pulse: switch fans off |
| load_dflt | output | 1 | One-cycle pulse: load default settings |
| run_normal | output | 1 | Normal operation, held until reset |

## Verification
Every output is registered. An input sampled at a rising edge shows its result on the outputs from that same edge onward. The countdown takes exactly TICKS counted ticks, so `fan_full` becomes visible right after the edge that samples the final tick. The bench advances a behavioural model at each rising edge and compares all four outputs at the following falling edge. Each result is therefore checked in the cycle it is due: a result that comes one cycle late, or that lingers for an extra cycle, shows as a mismatch.

// File: rtl/fanguard_pkg.sv
package fanguard_pkg;
    typedef enum logic [2:0] {
        ST_CHECK = 3'd0,
        ST_WAIT  = 3'd1,
        ST_COUNT = 3'd2,
        ST_FULL  = 3'd3,
        ST_RUN   = 3'd4
    } fg_state_t;
endpackage

// File: rtl/fanguard_timer.sv
module fanguard_timer #(
    parameter int TICKS = 4600
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(TICKS + 1);

    logic [CW-1:0] cnt;

    // Countdown restarts from zero whenever it is not running (R10)
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && (cnt != CW'(TICKS - 1))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && tick && (cnt == CW'(TICKS - 1));
endmodule

// File: rtl/fanguard_fsm.sv
module fanguard_fsm
    import fanguard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rail_ok,
    input  logic bus_hit,
    input  logic expire,
    output logic count_en,
    output logic fan_full,
    output logic fans_off,
    output logic load_dflt,
    output logic run_normal
);
    fg_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_CHECK;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CHECK: begin
                if (bus_hit)      nxt = ST_RUN;
                else if (rail_ok) nxt = ST_COUNT;
                else              nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (bus_hit)      nxt = ST_RUN;
                else if (rail_ok) nxt = ST_COUNT;
            end
            ST_COUNT: begin
                // an access beats an expiring tick in the same cycle
                if (bus_hit)     nxt = ST_RUN;
                else if (expire) nxt = ST_FULL;
            end
            ST_FULL: begin
                if (bus_hit) nxt = ST_RUN;
            end
            ST_RUN:  nxt = ST_RUN;
            default: nxt = ST_CHECK;
        endcase
    end

    assign count_en = (state == ST_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            fan_full   <= 1'b0;
            fans_off   <= 1'b0;
            load_dflt  <= 1'b0;
            run_normal <= 1'b0;
        end else begin
            fan_full   <= (nxt == ST_FULL);
            fans_off   <= (state == ST_FULL) && (nxt == ST_RUN);
            load_dflt  <= (state != ST_RUN) && (nxt == ST_RUN);
            run_normal <= (nxt == ST_RUN);
        end
    end
endmodule

// File: rtl/fanguard_seq.sv
module fanguard_seq #(
    parameter int TIMEOUT_US = 4_600_000,
    parameter int TICK_US    = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic rail_ok,
    input  logic bus_hit,
    input  logic tick,
    output logic fan_full,
    output logic fans_off,
    output logic load_dflt,
    output logic run_normal
);
    localparam int TICKS_RAW = TIMEOUT_US / TICK_US;
    localparam int TICKS     = (TICKS_RAW < 1) ? 1 : TICKS_RAW;

    logic count_en;
    logic expire;

    fanguard_timer #(.TICKS(TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (count_en),
        .tick   (tick),
        .expire (expire)
    );

    fanguard_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .rail_ok    (rail_ok),
        .bus_hit    (bus_hit),
        .expire     (expire),
        .count_en   (count_en),
        .fan_full   (fan_full),
        .fans_off   (fans_off),
        .load_dflt  (load_dflt),
        .run_normal (run_normal)
    );
endmodule

// File: rtl/fanguard_chk.sv
module fanguard_chk (
    input logic clk,
    input logic rst,
    input logic bus_hit,
    input logic fan_full,
    input logic fans_off,
    input logic load_dflt,
    input logic run_normal
);
    p_reset_clears_r9: assert property (@(posedge clk)
        rst |=> (!fan_full && !fans_off && !load_dflt && !run_normal));

    p_load_single_r8: assert property (@(posedge clk) disable iff (rst)
        load_dflt |=> !load_dflt);

    p_run_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        run_normal |=> run_normal);

    p_load_enters_run_r2: assert property (@(posedge clk) disable iff (rst)
        load_dflt |-> (run_normal && !$past(run_normal)));

    p_fansoff_with_load_r4: assert property (@(posedge clk) disable iff (rst)
        fans_off |-> (load_dflt && $past(fan_full)));

    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (fan_full && !bus_hit) |=> fan_full);

    p_full_excl_run_r3: assert property (@(posedge clk) disable iff (rst)
        fan_full |-> !run_normal);

    p_hit_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_hit && !fan_full) |=> (!fan_full && !fans_off));
endmodule

bind fanguard_seq fanguard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_hit    (bus_hit),
    .fan_full   (fan_full),
    .fans_off   (fans_off),
    .load_dflt  (load_dflt),
    .run_normal (run_normal)
);

// File: tb/test_fanguard_seq.sv
module test_fanguard_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rail_ok = 1'b0;
    logic bus_hit = 1'b0;
    logic tick = 1'b0;
    logic fan_full, fans_off, load_dflt, run_normal;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    // behavioural reference
    int  mode = 0;   // 0 check, 1 wait, 2 count, 3 full, 4 run
    int  ticks = 0;
    bit  e_full = 0, e_off = 0, e_ld = 0, e_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fanguard_seq #(.TIMEOUT_US(4_600_000), .TICK_US(460_000)) i_fanguard_seq (
        .clk        (clk),
        .rst        (rst),
        .rail_ok    (rail_ok),
        .bus_hit    (bus_hit),
        .tick       (tick),
        .fan_full   (fan_full),
        .fans_off   (fans_off),
        .load_dflt  (load_dflt),
        .run_normal (run_normal)
    );

    always @(posedge clk) begin
        e_ld  = 0;
        e_off = 0;
        if (rst) begin
            mode = 0;
            ticks = 0;
        end else begin
            case (mode)
                0, 1: begin
                    if (bus_hit) begin mode = 4; e_ld = 1; end
                    else if (rail_ok) begin mode = 2; ticks = 0; end
                    else mode = 1;
                end
                2: begin
                    if (bus_hit) begin mode = 4; e_ld = 1; end
                    else if (tick) begin
                        ticks = ticks + 1;
                        if (ticks == TO) mode = 3;
                    end
                end
                3: if (bus_hit) begin mode = 4; e_ld = 1; e_off = 1; end
                default: ;
            endcase
        end
        e_full = (mode == 3);
        e_run  = (mode == 4);
    end

    task automatic chk(string nm, logic act, bit exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, nm, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        chk("fan_full",   fan_full,   e_full);
        chk("fans_off",   fans_off,   e_off);
        chk("load_dflt",  load_dflt,  e_ld);
        chk("run_normal", run_normal, e_run);
    end

    task automatic cyc(bit h, bit t);
        bus_hit = h;
        tick = t;
        @(negedge clk);
    endtask

    task automatic do_reset(bit rail);
        rst = 1'b1;
        rail_ok = rail;
        cyc(0, 0);
        cyc(0, 0);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        cur_req = "R1";
        do_reset(1);
        cyc(0, 0);

        cur_req = "R2";
        for (int i = 0; i < 4; i++) cyc(0, 1);
        cyc(1, 0);
        cur_req = "R8";
        for (int i = 0; i < 4; i++) cyc(1, 1);
        cyc(0, 0);

        cur_req = "R3";
        do_reset(1);
        for (int i = 0; i < 14; i++) cyc(0, i % 2);
        for (int i = 0; i < 10; i++) cyc(0, 1);
        cur_req = "R4";
        cyc(1, 0);
        cyc(0, 0);
        cur_req = "R8";
        cyc(1, 0);
        cyc(0, 1);

        cur_req = "R5";
        do_reset(0);
        for (int i = 0; i < 20; i++) cyc(0, 1);
        cyc(1, 0);
        cyc(0, 0);

        cur_req = "R6";
        do_reset(0);
        for (int i = 0; i < 5; i++) cyc(0, 1);
        rail_ok = 1'b1;
        for (int i = 0; i < 13; i++) cyc(0, 1);
        cur_req = "R9";
        rst = 1'b1;
        cyc(0, 0);
        rst = 1'b0;
        rail_ok = 1'b0;
        cyc(0, 0);
        cyc(1, 0);
        rst = 1'b1;
        cyc(0, 0);
        rst = 1'b0;
        cyc(0, 0);

        cur_req = "R7";
        do_reset(1);
        cyc(0, 0);
        for (int i = 0; i < 9; i++) cyc(0, 1);
        cyc(1, 1);
        cyc(0, 0);

        cur_req = "R10";
        do_reset(1);
        for (int i = 0; i < 6; i++) cyc(0, 1);
        rst = 1'b1;
        cyc(0, 0);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) cyc(0, 1);
        cyc(0, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule